// File: doc/BRIEF.md
# Clock Controller Register File

This block is the software-visible register bank of a clock control unit. A 32-bit port that is addressed by word index reaches nine registers: a mode word, two post-divider words, two PLL control words, three clock-gating words and a power-management word. It also reaches one fixed status word. Each register keeps only the bits it implements. The mode register additionally forces one bit high on every write. The power-management word can be read but not written.

The clock-frequency model sits elsewhere and reads the register contents from this block. When a write lands on a register that changes a derived frequency, the bank raises a one-cycle `recompute` pulse so that downstream logic knows to re-evaluate. The same pulse is also issued once after reset, so the model starts from the reset contents. Writes that only gate clocks, and writes that land on unmapped words, do not raise the pulse.

Top module: `clkctl_regfile`

## Requirements
- R1: After reset the registers hold these values. Mode (word 0) holds 0x074B0B7B. Divider 0 (word 1) holds 0xFF870B48. Divider 1 (word 2) holds 0x49FCFE7F. Main PLL (word 4) holds 0x04001800, which is pre-divider field 1 at bits 29:26, denominator field 0 at bits 25:16, integer 6 at bits 13:10 and numerator 0 at bits 9:0. Secondary PLL (word 6) holds 0x04043001, which is pre-divider 1, denominator 4, integer 12 and numerator 1. Gating words 8, 9 and 10 hold 0xFFFFFFFF. Power-management (word 23) holds 0x80209828.
- R2: A read of word 18 returns 0x00004040. A read of any word outside the map returns zero.
- R3: A write to the mode word stores (data & 0x3B6FDFFF) | (1<<26).
- R4: A write to divider 0 stores data & 0xFF9F3FFF. A write to divider 1 stores the data unchanged.
- R5: A write to either PLL control word stores data & 0xBFFF3FFF.
- R6: A gating word stores the written data unchanged, and writing it raises no recompute pulse.
- R7: A write to the power-management word leaves its content unchanged and raises no recompute pulse.
- R8: A write to the mode, divider or PLL words raises `recompute` for exactly the one cycle after the write.
- R9: `recompute` is high for exactly one cycle right after reset is released.
- R10: A read request yields `rsp_valid` high, together with the data, in the cycle after the request. `rsp_valid` is low in every cycle that does not follow a read request.
- R11: A write to an unmapped word, or to the status word 18, changes no readable value and raises no recompute pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_rdata | output | 32 | Registered read data |
| recompute | output | 1 | One-cycle pulse requesting a frequency re-evaluation |

## Verification
The write masks are exercised with all-ones data, which exposes every stored bit. They are also exercised with all-zeros data, and for the mode word this shows that the forced bit appears even when it is not written. Checkerboard and mixed patterns on the unmasked words show that no mask has been applied to them. A PLL pattern that touches only masked-off bits must read back as zero. Writes to the read-only word, the status word and an unmapped word each have a matching read-back and a recompute check, which separate "stored", "ignored" and "decoded as something else".

// File: rtl/ckreg_pkg.sv
package ckreg_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 10;
    localparam int NUM_GATE  = 3;
    localparam int IDX_MODE  = 0;
    localparam int IDX_DIV0  = 1;
    localparam int IDX_DIV1  = 2;
    localparam int IDX_MPLL  = 3;
    localparam int IDX_SPLL  = 4;
    localparam int IDX_GATE0 = 5;
    localparam int IDX_PM    = IDX_GATE0 + NUM_GATE;
    localparam int NREG      = IDX_PM + 1;
    localparam int MODE_FORCE_BIT = 26;

    localparam logic [ADDR_W-1:0] STATUS_OFS  = ADDR_W'(18);
    localparam logic [DATA_W-1:0] STATUS_WORD = 32'h0000_4040;

    typedef logic [NREG-1:0][DATA_W-1:0] reg_vec_t;

    // Word index of each register slot
    function automatic logic [ADDR_W-1:0] reg_offset(input int idx);
        case (idx)
            IDX_MODE: return ADDR_W'(0);
            IDX_DIV0: return ADDR_W'(1);
            IDX_DIV1: return ADDR_W'(2);
            IDX_MPLL: return ADDR_W'(4);
            IDX_SPLL: return ADDR_W'(6);
            IDX_PM:   return ADDR_W'(23);
            default:  return ADDR_W'(8 + idx - IDX_GATE0);
        endcase
    endfunction

    // Assemble a PLL control word from its fields
    function automatic logic [DATA_W-1:0] pll_word(input logic [3:0] pre,
                                                   input logic [9:0] den,
                                                   input logic [3:0] intg,
                                                   input logic [9:0] num);
        return (DATA_W'(pre) << 26) | (DATA_W'(den) << 16) |
               (DATA_W'(intg) << 10) | DATA_W'(num);
    endfunction

    function automatic logic [DATA_W-1:0] reset_val(input int idx);
        case (idx)
            IDX_MODE: return 32'h074B_0B7B;
            IDX_DIV0: return 32'hFF87_0B48;
            IDX_DIV1: return 32'h49FC_FE7F;
            IDX_MPLL: return pll_word(4'd1, 10'd0, 4'd6, 10'd0);
            IDX_SPLL: return pll_word(4'd1, 10'd4, 4'd12, 10'd1);
            IDX_PM:   return 32'h8020_9828;
            default:  return '1;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] wr_mask(input int idx);
        case (idx)
            IDX_MODE: return 32'h3B6F_DFFF;
            IDX_DIV0: return 32'hFF9F_3FFF;
            IDX_MPLL, IDX_SPLL: return 32'hBFFF_3FFF;
            IDX_PM:   return '0;
            default:  return '1;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] wr_set(input int idx);
        return (idx == IDX_MODE) ? (DATA_W'(1) << MODE_FORCE_BIT) : '0;
    endfunction

    function automatic logic is_writable(input int idx);
        return idx != IDX_PM;
    endfunction

    function automatic logic is_freq(input int idx);
        return idx <= IDX_SPLL;
    endfunction
endpackage

// File: rtl/ckreg_decode.sv
module ckreg_decode
    import ckreg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   sel,
    output logic              is_status
);
    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign sel[g] = (addr == reg_offset(g));
    end
    assign is_status = (addr == STATUS_OFS);
endmodule

// File: rtl/ckreg_bank.sv
module ckreg_bank
    import ckreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NREG-1:0]   sel,
    input  logic [DATA_W-1:0] wdata,
    output reg_vec_t          regs,
    output logic              recompute
);
    typedef struct packed {
        reg_vec_t r;
        logic     pulse;
        logic     boot;
    } bank_st_t;

    function automatic bank_st_t reset_state();
        bank_st_t s;
        for (int i = 0; i < NREG; i++) s.r[i] = reset_val(i);
        s.pulse = 1'b0;
        s.boot  = 1'b1;
        return s;
    endfunction

    bank_st_t st_d, st_q;

    always_comb begin
        logic hit_freq;
        st_d     = st_q;
        hit_freq = 1'b0;
        st_d.boot = 1'b0;
        if (wr_en) begin
            for (int i = 0; i < NREG; i++) begin
                if (sel[i] && is_writable(i)) begin
                    st_d.r[i] = (wdata & wr_mask(i)) | wr_set(i);
                    if (is_freq(i)) hit_freq = 1'b1;
                end
            end
        end
        st_d.pulse = hit_freq | st_q.boot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    assign regs      = st_q.r;
    assign recompute = st_q.pulse;

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    // R3
    mode_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel[IDX_MODE]) |=> st_q.r[IDX_MODE][MODE_FORCE_BIT]);
    // R4
    div0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel[IDX_DIV0]) |=> ((st_q.r[IDX_DIV0] & ~32'hFF9F_3FFF) == '0));
    // R7
    pm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel[IDX_PM]) |=> $stable(st_q.r[IDX_PM]));
    // R8
    freq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel[IDX_MODE] || sel[IDX_MPLL] || sel[IDX_SPLL])) |=> recompute);
endmodule

// File: rtl/ckreg_rdmux.sv
module ckreg_rdmux
    import ckreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [NREG-1:0]   sel,
    input  logic              is_status,
    input  reg_vec_t          regs,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } rd_st_t;

    rd_st_t rd_d, rd_q;

    always_comb begin
        logic [DATA_W-1:0] word;
        word = is_status ? STATUS_WORD : '0;
        for (int i = 0; i < NREG; i++)
            if (sel[i]) word = word | regs[i];
        rd_d.vld  = rd_en;
        rd_d.data = rd_en ? word : rd_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rsp_valid = rd_q.vld;
    assign rsp_rdata = rd_q.data;

    // R10
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rsp_valid);
    // R10
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rsp_valid);
endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
    import ckreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              recompute
);
    logic [NREG-1:0] sel;
    logic            is_status;
    reg_vec_t        regs;

    ckreg_decode u_dec (
        .addr      (req_addr),
        .sel       (sel),
        .is_status (is_status)
    );

    ckreg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (req_valid && req_write),
        .sel       (sel),
        .wdata     (req_wdata),
        .regs      (regs),
        .recompute (recompute)
    );

    ckreg_rdmux u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (req_valid && !req_write),
        .sel       (sel),
        .is_status (is_status),
        .regs      (regs),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: tb/sim_clkctl_regfile.sv
module sim_clkctl_regfile;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic        req_write = 0;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        recompute;
    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    clkctl_regfile u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Write, then check the recompute pulse in the next cycle and its drop after
    task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic exp_rc, input string tag);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        check({tag, " recompute"}, 32'(recompute), 32'(exp_rc));
        @(negedge clk);
        check({tag, " recompute drop"}, 32'(recompute), 0);
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        check({tag, " rsp_valid (R10)"}, 32'(rsp_valid), 1);
        check(tag, rsp_rdata, exp);
        @(negedge clk);
        check({tag, " rsp_valid drop (R10)"}, 32'(rsp_valid), 0);
    endtask

    task automatic t_reset();
        check("R9 recompute in reset", 32'(recompute), 0);
        check("R10 rsp_valid in reset", 32'(rsp_valid), 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check("R9 boot pulse", 32'(recompute), 1);
        @(negedge clk);
        check("R9 boot pulse drop", 32'(recompute), 0);
        rd(0,  32'h074B0B7B, "R1 mode");
        rd(1,  32'hFF870B48, "R1 div0");
        rd(2,  32'h49FCFE7F, "R1 div1");
        rd(4,  32'h04001800, "R1 main pll");
        rd(6,  32'h04043001, "R1 sec pll");
        rd(8,  32'hFFFFFFFF, "R1 gate0");
        rd(9,  32'hFFFFFFFF, "R1 gate1");
        rd(10, 32'hFFFFFFFF, "R1 gate2");
        rd(23, 32'h80209828, "R1 pm");
    endtask

    task automatic t_status();
        rd(18, 32'h00004040, "R2 status");
        rd(3,  32'h0, "R2 unmapped 3");
        rd(1023, 32'h0, "R2 unmapped 1023");
    endtask

    task automatic t_mode();
        wr(0, 32'hFFFFFFFF, 1, "R8 mode ones");
        rd(0, 32'h3F6FDFFF, "R3 mode ones");
        wr(0, 32'h0, 1, "R8 mode zero");
        rd(0, 32'h04000000, "R3 mode zero");
    endtask

    task automatic t_div();
        wr(1, 32'hFFFFFFFF, 1, "R8 div0");
        rd(1, 32'hFF9F3FFF, "R4 div0 mask");
        wr(2, 32'h12345678, 1, "R8 div1");
        rd(2, 32'h12345678, "R4 div1 raw");
    endtask

    task automatic t_pll();
        wr(4, 32'hFFFFFFFF, 1, "R8 main pll");
        rd(4, 32'hBFFF3FFF, "R5 main pll mask");
        wr(6, 32'h4000C000, 1, "R8 sec pll");
        rd(6, 32'h00000000, "R5 sec pll masked bits");
    endtask

    task automatic t_gate();
        wr(9, 32'hA5A50F0F, 0, "R6 gate1");
        rd(9, 32'hA5A50F0F, "R6 gate1 raw");
        rd(8, 32'hFFFFFFFF, "R6 gate0 untouched");
        wr(10, 32'h0, 0, "R6 gate2");
        rd(10, 32'h0, "R6 gate2 zero");
    endtask

    task automatic t_pm();
        wr(23, 32'h0, 0, "R7 pm");
        rd(23, 32'h80209828, "R7 pm kept");
    endtask

    task automatic t_unmapped();
        wr(3, 32'hFFFFFFFF, 0, "R11 word 3");
        rd(3, 32'h0, "R11 word 3 read");
        wr(18, 32'hFFFFFFFF, 0, "R11 status write");
        rd(18, 32'h00004040, "R11 status kept");
        rd(0, 32'h04000000, "R11 mode kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_status();
        t_mode();
        t_div();
        t_pll();
        t_gate();
        t_pm();
        t_unmapped();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule